// File: doc/BRIEF.md
# Software-Reloaded Translation Buffer with Reload Assist

This block is a small fully associative translation buffer for 4 KB pages. A processor refills it mostly in software. Each lookup compares the effective page number against every valid slot. One cycle later the block reports one of four outcomes: a translated real address, a miss, an error with a cause code, or an untranslated pass-through when translation is switched off.

The block does not walk the page tables. It only keeps the context that the refill software needs. On the first cycle of a miss it latches the missed page number and advances a round-robin victim counter. The counter can be limited so that the top slots are never chosen and act as locked entries. The block also forms two table-walk pointers by concatenation. One joins the level-one table base with the upper half of the missed page number. The other joins the level-two base, taken from the fetched level-one entry, with the lower half. When software writes the real-page port, the latched page number, the given real page and the attributes are installed into the victim slot. Software can also drop every slot at once, or only the slots that hold a given page number.

Top module: `soft_tlb`

## Requirements
- R1: With `xlateEn` low, a lookup returns `resultPa` equal to `lookupEa` one cycle later, with `resultMiss` and `resultErr` low.
- R2: With `xlateEn` high and a valid slot matching `lookupEa[31:12]` without fault, one cycle after the lookup `resultValid` is high and `resultPa` is {slot real page, `lookupEa[11:0]`}. If several slots match, the lowest index wins.
- R3: With `xlateEn` high and no valid slot matching, `resultMiss` is high one cycle later and `resultPa` is 0. `capEpn` captures the missed page number only when no miss is already pending, and holds it until a real-page write.
- R4: On each newly captured miss the victim counter `victimIdx` advances by one. It wraps to 0 after 31 when `cfgLockTop` is 0, and after 27 when `cfgLockTop` is 1. In the second case slots 28 to 31 are never chosen. Reset value is 0.
- R5: A pulse on `rpnWrEn` writes the captured page number, `rpnWrPpn` and `rpnWrAttr` into slot `victimIdx`, marks the slot valid and clears the pending miss.
- R6: An error replaces a hit. The attribute bits are [3] page valid, [2] writable, [1] guarded, [0] changed. `resultCode` is 0 for a page-valid bit of 0; otherwise 1 for a store to a non-writable page, then 2 for a fetch from a guarded page, then 3 for a store to a page whose changed bit is 0. The codes are checked in that priority order. `resultMiss` and `resultErr` are never high together.
- R7: `twbPtr` equals {`l1Base`, `capEpn[19:10]`, 2'b00}.
- R8: `twcPtr` equals {`l2Base`, `capEpn[9:0]`, 2'b00}.
- R9: `invAll` clears every slot, so later lookups miss.
- R10: `invOne` clears only the slots whose page number equals `invEpn`; other slots keep translating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xlateEn | input | 1 | Translation enable |
| cfgLockTop | input | 1 | Limit victim choice to slots 0 to 27 |
| lookupValid | input | 1 | Lookup request |
| lookupEa | input | 32 | Effective address |
| lookupIsFetch | input | 1 | Access is an instruction fetch |
| lookupIsStore | input | 1 | Access is a store |
| rpnWrEn | input | 1 | Real-page write, installs victim slot |
| rpnWrPpn | input | 20 | Real page number to install |
| rpnWrAttr | input | 4 | Attributes to install |
| invAll | input | 1 | Clear all slots |
| invOne | input | 1 | Clear slots matching `invEpn` |
| invEpn | input | 20 | Page number to clear |
| l1Base | input | 20 | Level-one table base |
| l2Base | input | 20 | Level-two base from fetched level-one entry |
| resultValid | output | 1 | Registered result valid |
| resultPa | output | 32 | Real address |
| resultMiss | output | 1 | Miss |
| resultErr | output | 1 | Error |
| resultCode | output | 2 | Error cause |
| victimIdx | output | 5 | Replacement index |
| capEpn | output | 20 | Captured missed page number |
| twbPtr | output | 32 | Level-one walk pointer |
| twcPtr | output | 32 | Level-two walk pointer |

## Verification
The wrap points of the victim counter are the hardest to reach. Reaching them takes dozens of complete miss-then-install rounds with distinct pages, and any stray lookup while a miss is pending must not move the counter. The stimulus runs a loop of more than 32 such rounds with the range limit set, then the same loop with it cleared. A behavioural model tracks the counter and slot contents on every clock. The error priorities are covered by installing pages with chosen attribute sets and mixing fetches, loads and stores against them.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  typedef struct packed {
    logic pageOk;
    logic writeOk;
    logic guarded;
    logic changed;
  } tlbAttr_t;

  typedef struct packed {
    logic install;
    logic clearAll;
    logic clearOne;
  } tlbStrobe_t;

  typedef enum logic [1:0] {
    ERR_PAGE   = 2'd0,
    ERR_PROT   = 2'd1,
    ERR_GUARD  = 2'd2,
    ERR_CHANGE = 2'd3
  } tlbErr_t;
endpackage

// File: rtl/soft_tlb_ctrl.sv
module soft_tlb_ctrl
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES    = 32,
  parameter int LOCK_LIMIT = 28,
  parameter int EA_W       = 32,
  parameter int PAGE_BITS  = 12,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int EPN_W     = EA_W - PAGE_BITS,
  localparam int L1_IDX_W  = EPN_W / 2,
  localparam int L2_IDX_W  = EPN_W - L1_IDX_W,
  localparam int L1B_W     = EA_W - L1_IDX_W - 2,
  localparam int L2B_W     = EA_W - L2_IDX_W - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xlateEn,
  input  logic             cfgLockTop,
  input  logic             lookupValid,
  input  logic [EPN_W-1:0] lookupEpn,
  input  logic             hit,
  input  logic             rpnWrEn,
  input  logic             invAll,
  input  logic             invOne,
  input  logic [L1B_W-1:0] l1Base,
  input  logic [L2B_W-1:0] l2Base,
  output tlbStrobe_t       stb,
  output logic [IDX_W-1:0] victimIdx,
  output logic [EPN_W-1:0] capEpn,
  output logic [EA_W-1:0]  twbPtr,
  output logic [EA_W-1:0]  twcPtr
);
  logic             missPend;
  logic             missNew;
  logic [IDX_W:0]   ctrInc;
  logic [IDX_W:0]   ctrLimit;
  logic [IDX_W-1:0] ctrNext;

  assign missNew  = lookupValid && xlateEn && !hit && !missPend;
  assign ctrInc   = {1'b0, victimIdx} + 1'b1;
  assign ctrLimit = cfgLockTop ? (IDX_W+1)'(LOCK_LIMIT) : (IDX_W+1)'(ENTRIES);
  assign ctrNext  = (ctrInc >= ctrLimit) ? '0 : ctrInc[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missPend  <= 1'b0;
      victimIdx <= '0;
      capEpn    <= '0;
    end else if (missNew) begin
      missPend  <= 1'b1;
      victimIdx <= ctrNext;
      capEpn    <= lookupEpn;
    end else if (rpnWrEn) begin
      missPend  <= 1'b0;
    end
  end

  always_comb begin
    stb.install  = rpnWrEn;
    stb.clearAll = invAll;
    stb.clearOne = invOne;
  end

  assign twbPtr = {l1Base, capEpn[EPN_W-1 -: L1_IDX_W], 2'b00};
  assign twcPtr = {l2Base, capEpn[L2_IDX_W-1:0], 2'b00};

  p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    missNew |=> capEpn == $past(lookupEpn));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (missPend && !rpnWrEn) |=> $stable(capEpn));
  p_lock_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (missNew && cfgLockTop) |=> victimIdx < IDX_W'(LOCK_LIMIT));
endmodule

// File: rtl/soft_tlb_dp.sv
module soft_tlb_dp
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int EA_W      = 32,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int EPN_W    = EA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       stb,
  input  logic [IDX_W-1:0] installIdx,
  input  logic [EPN_W-1:0] installEpn,
  input  logic [EPN_W-1:0] rpnWrPpn,
  input  logic [3:0]       rpnWrAttr,
  input  logic [EPN_W-1:0] invEpn,
  input  logic             xlateEn,
  input  logic             lookupValid,
  input  logic [EA_W-1:0]  lookupEa,
  input  logic             lookupIsFetch,
  input  logic             lookupIsStore,
  output logic             hit,
  output logic             resultValid,
  output logic [EA_W-1:0]  resultPa,
  output logic             resultMiss,
  output logic             resultErr,
  output logic [1:0]       resultCode
);
  logic [ENTRIES-1:0] validVec;
  logic [EPN_W-1:0]   tagMem [ENTRIES];
  logic [EPN_W-1:0]   ppnMem [ENTRIES];
  tlbAttr_t           attrMem[ENTRIES];

  logic [EPN_W-1:0] lookupEpn;
  logic [IDX_W-1:0] hitIdx;
  tlbAttr_t         hitAttr;
  logic             errNow;
  tlbErr_t          errCode;
  logic [EA_W-1:0]  paNow;

  assign lookupEpn = lookupEa[EA_W-1:PAGE_BITS];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validVec[g] <= 1'b0;
      end else begin
        if (stb.clearAll) validVec[g] <= 1'b0;
        else if (stb.clearOne && tagMem[g] == invEpn) validVec[g] <= 1'b0;
        if (stb.install && installIdx == IDX_W'(g)) validVec[g] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (stb.install && installIdx == IDX_W'(g)) begin
        tagMem[g]  <= installEpn;
        ppnMem[g]  <= rpnWrPpn;
        attrMem[g] <= tlbAttr_t'(rpnWrAttr);
      end
    end
  end

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (validVec[i] && tagMem[i] == lookupEpn) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    hitAttr = attrMem[hitIdx];
    errNow  = 1'b1;
    errCode = ERR_PAGE;
    if (!hitAttr.pageOk)                          errCode = ERR_PAGE;
    else if (lookupIsStore && !hitAttr.writeOk)   errCode = ERR_PROT;
    else if (lookupIsFetch && hitAttr.guarded)    errCode = ERR_GUARD;
    else if (lookupIsStore && !hitAttr.changed)   errCode = ERR_CHANGE;
    else                                          errNow  = 1'b0;
    if (!xlateEn)  paNow = lookupEa;
    else if (hit)  paNow = {ppnMem[hitIdx], lookupEa[PAGE_BITS-1:0]};
    else           paNow = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultPa    <= '0;
      resultMiss  <= 1'b0;
      resultErr   <= 1'b0;
      resultCode  <= '0;
    end else begin
      resultValid <= lookupValid;
      resultPa    <= lookupValid ? paNow : '0;
      resultMiss  <= lookupValid && xlateEn && !hit;
      resultErr   <= lookupValid && xlateEn && hit && errNow;
      resultCode  <= (lookupValid && xlateEn && hit && errNow) ? errCode : ERR_PAGE;
    end
  end

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !xlateEn) |=>
      (resultValid && !resultMiss && !resultErr && resultPa == $past(lookupEa)));
  p_install_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.install && !stb.clearAll) |=> validVec[$past(installIdx)]);
  p_miss_err_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(resultMiss && resultErr));
  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clearAll && !stb.install) |=> validVec == '0);
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES    = 32,
  parameter int LOCK_LIMIT = 28,
  parameter int EA_W       = 32,
  parameter int PAGE_BITS  = 12,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int EPN_W     = EA_W - PAGE_BITS,
  localparam int L1B_W     = EA_W - EPN_W / 2 - 2,
  localparam int L2B_W     = EA_W - (EPN_W - EPN_W / 2) - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xlateEn,
  input  logic             cfgLockTop,
  input  logic             lookupValid,
  input  logic [EA_W-1:0]  lookupEa,
  input  logic             lookupIsFetch,
  input  logic             lookupIsStore,
  input  logic             rpnWrEn,
  input  logic [EPN_W-1:0] rpnWrPpn,
  input  logic [3:0]       rpnWrAttr,
  input  logic             invAll,
  input  logic             invOne,
  input  logic [EPN_W-1:0] invEpn,
  input  logic [L1B_W-1:0] l1Base,
  input  logic [L2B_W-1:0] l2Base,
  output logic             resultValid,
  output logic [EA_W-1:0]  resultPa,
  output logic             resultMiss,
  output logic             resultErr,
  output logic [1:0]       resultCode,
  output logic [IDX_W-1:0] victimIdx,
  output logic [EPN_W-1:0] capEpn,
  output logic [EA_W-1:0]  twbPtr,
  output logic [EA_W-1:0]  twcPtr
);
  tlbStrobe_t stb;
  logic       hit;

  soft_tlb_ctrl #(
    .ENTRIES(ENTRIES), .LOCK_LIMIT(LOCK_LIMIT), .EA_W(EA_W), .PAGE_BITS(PAGE_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .xlateEn(xlateEn), .cfgLockTop(cfgLockTop),
    .lookupValid(lookupValid), .lookupEpn(lookupEa[EA_W-1:PAGE_BITS]), .hit(hit),
    .rpnWrEn(rpnWrEn), .invAll(invAll), .invOne(invOne),
    .l1Base(l1Base), .l2Base(l2Base), .stb(stb), .victimIdx(victimIdx),
    .capEpn(capEpn), .twbPtr(twbPtr), .twcPtr(twcPtr)
  );

  soft_tlb_dp #(
    .ENTRIES(ENTRIES), .EA_W(EA_W), .PAGE_BITS(PAGE_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .installIdx(victimIdx), .installEpn(capEpn),
    .rpnWrPpn(rpnWrPpn), .rpnWrAttr(rpnWrAttr), .invEpn(invEpn), .xlateEn(xlateEn),
    .lookupValid(lookupValid), .lookupEa(lookupEa), .lookupIsFetch(lookupIsFetch),
    .lookupIsStore(lookupIsStore), .hit(hit), .resultValid(resultValid),
    .resultPa(resultPa), .resultMiss(resultMiss), .resultErr(resultErr),
    .resultCode(resultCode)
  );
endmodule

// File: tb/sim_soft_tlb.sv
module sim_soft_tlb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xlateEn = 1'b0, cfgLockTop = 1'b0;
  logic        lookupValid = 1'b0, lookupIsFetch = 1'b0, lookupIsStore = 1'b0;
  logic [31:0] lookupEa = '0;
  logic        rpnWrEn = 1'b0;
  logic [19:0] rpnWrPpn = '0;
  logic [3:0]  rpnWrAttr = '0;
  logic        invAll = 1'b0, invOne = 1'b0;
  logic [19:0] invEpn = '0;
  logic [19:0] l1Base = 20'hABCDE, l2Base = 20'h13579;
  logic        resultValid, resultMiss, resultErr;
  logic [31:0] resultPa, twbPtr, twcPtr;
  logic [1:0]  resultCode;
  logic [4:0]  victimIdx;
  logic [19:0] capEpn;

  always #2 clk = ~clk;

  soft_tlb u0 (
    .clk(clk), .rstN(rstN), .xlateEn(xlateEn), .cfgLockTop(cfgLockTop),
    .lookupValid(lookupValid), .lookupEa(lookupEa), .lookupIsFetch(lookupIsFetch),
    .lookupIsStore(lookupIsStore), .rpnWrEn(rpnWrEn), .rpnWrPpn(rpnWrPpn),
    .rpnWrAttr(rpnWrAttr), .invAll(invAll), .invOne(invOne), .invEpn(invEpn),
    .l1Base(l1Base), .l2Base(l2Base), .resultValid(resultValid), .resultPa(resultPa),
    .resultMiss(resultMiss), .resultErr(resultErr), .resultCode(resultCode),
    .victimIdx(victimIdx), .capEpn(capEpn), .twbPtr(twbPtr), .twcPtr(twcPtr)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;
  string req = "R1";

  bit          mValid[32];
  logic [19:0] mEpn[32], mPpn[32];
  logic [3:0]  mAttr[32];
  int          mCtr = 0;
  bit          mPend = 0;
  logic [19:0] mCap = '0;

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic tick();
    bit hitM = 0; int hi = 0; bit missNew; int lim;
    logic eV, eMiss, eErr; logic [31:0] ePa; logic [1:0] eCode;
    logic [3:0] a;
    for (int i = 31; i >= 0; i--)
      if (mValid[i] && mEpn[i] == lookupEa[31:12]) begin hitM = 1; hi = i; end
    eV = lookupValid; eMiss = 0; eErr = 0; eCode = 0; ePa = 0;
    if (lookupValid) begin
      if (!xlateEn) ePa = lookupEa;
      else if (!hitM) eMiss = 1;
      else begin
        ePa = {mPpn[hi], lookupEa[11:0]};
        a = mAttr[hi];
        eErr = 1;
        if (!a[3]) eCode = 0;
        else if (lookupIsStore && !a[2]) eCode = 1;
        else if (lookupIsFetch && a[1]) eCode = 2;
        else if (lookupIsStore && !a[0]) eCode = 3;
        else eErr = 0;
        if (!eErr) eCode = 0;
      end
    end
    missNew = lookupValid && xlateEn && !hitM && !mPend;
    if (invAll) for (int i = 0; i < 32; i++) mValid[i] = 0;
    else if (invOne) for (int i = 0; i < 32; i++) if (mEpn[i] == invEpn) mValid[i] = 0;
    if (rpnWrEn) begin
      mValid[mCtr] = 1; mEpn[mCtr] = mCap; mPpn[mCtr] = rpnWrPpn; mAttr[mCtr] = rpnWrAttr;
    end
    lim = cfgLockTop ? 28 : 32;
    if (missNew) begin
      mPend = 1; mCap = lookupEa[31:12];
      mCtr = (mCtr + 1 >= lim) ? 0 : mCtr + 1;
    end else if (rpnWrEn) mPend = 0;
    @(posedge clk);
    @(negedge clk);
    chk(req, "resultValid", 32'(resultValid), 32'(eV));
    chk(req, "resultPa", resultPa, ePa);
    chk(req, "resultMiss", 32'(resultMiss), 32'(eMiss));
    chk(req, "resultErr/code", {29'd0, resultErr, resultCode}, {29'd0, eErr, eCode});
    chk("R4", "victimIdx", 32'(victimIdx), 32'(mCtr));
    chk("R3", "capEpn", 32'(capEpn), 32'(mCap));
    chk("R7", "twbPtr", twbPtr, {l1Base, mCap[19:10], 2'b00});
    chk("R8", "twcPtr", twcPtr, {l2Base, mCap[9:0], 2'b00});
    lookupValid = 0; lookupIsFetch = 0; lookupIsStore = 0;
    rpnWrEn = 0; invAll = 0; invOne = 0;
  endtask

  task automatic look(logic [31:0] ea, bit f, bit s);
    lookupValid = 1; lookupEa = ea; lookupIsFetch = f; lookupIsStore = s;
    tick();
  endtask

  task automatic install(logic [19:0] ppn, logic [3:0] attr);
    rpnWrEn = 1; rpnWrPpn = ppn; rpnWrAttr = attr;
    tick();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin mValid[i] = 0; mEpn[i] = '0; mPpn[i] = '0; mAttr[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R4", "reset victimIdx", 32'(victimIdx), 0);
    chk("R3", "reset capEpn", 32'(capEpn), 0);
    chk("R2", "reset resultValid", 32'(resultValid), 0);
    rstN = 1;
    @(negedge clk);
    // R1 pass-through
    req = "R1";
    look(32'h1234_5678, 0, 0);
    look(32'hFFFF_F001, 1, 0);
    look(32'h0000_0ABC, 0, 1);
    // R3 miss and capture, held on second miss
    xlateEn = 1; req = "R3";
    look(32'h1234_5678, 0, 0);
    look(32'h2222_2000, 0, 0);
    l1Base = 20'h0F0F0; l2Base = 20'hC3C3C; req = "R7";
    tick();
    // R5 install then R2 hit
    req = "R5"; install(20'h00F0F, 4'b1111);
    req = "R2"; look(32'h1234_5678, 0, 1);
    look(32'h1234_5FFF, 1, 0);
    // R6 error causes
    req = "R6";
    look(32'hA000_0100, 0, 0); install(20'h0000A, 4'b0111);
    look(32'hB000_0100, 0, 0); install(20'h0000B, 4'b1011);
    look(32'hC000_0100, 0, 0); install(20'h0000C, 4'b1110);
    look(32'hA000_0200, 0, 0);
    look(32'hB000_0300, 0, 1);
    look(32'hB000_0304, 0, 0);
    look(32'hB000_0308, 1, 0);
    look(32'hC000_0400, 1, 0);
    look(32'hC000_0404, 0, 1);
    look(32'hC000_0408, 1, 1);
    // R10 clear one page
    req = "R10"; invOne = 1; invEpn = 20'hA0000; tick();
    look(32'hA000_0000, 0, 0);
    look(32'hB000_0000, 0, 0);
    install(20'h0000D, 4'b1111);
    // R9 clear all
    req = "R9"; invAll = 1; tick();
    look(32'hB000_0000, 0, 0);
    look(32'h1234_5000, 0, 0);
    install(20'h00001, 4'b1111);
    // R4 wrap with lock then without
    req = "R4"; cfgLockTop = 1;
    for (int k = 0; k < 34; k++) begin
      look({20'h40000 + 20'(k), 12'h010}, 0, 0);
      install(20'h50000 + 20'(k), 4'b1111);
    end
    cfgLockTop = 0;
    for (int k = 0; k < 36; k++) begin
      look({20'h60000 + 20'(k), 12'h020}, 0, 0);
      install(20'h70000 + 20'(k), 4'b1111);
    end
    req = "R2"; look(32'h6002_3ABC, 0, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule